// File: doc/BRIEF.md
# Auxiliary I/O and System-Control Register Block

This block is a set of small control registers on a simple request bus. It holds a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a system-control byte read as a 32-bit word. Several registers have side effects. A write to the first auxiliary register can send a one-clock terminal-count strobe to a floppy controller. The second auxiliary register latches a power-fail status and drives a power-off request. A write to system control can raise a one-clock reset-request strobe and leave a reset-status mark that outlives the reset.

A request is one cycle long. `req_valid` is high with the select, offset, size code and write data. The write takes effect at that clock edge, and read data appears on `rsp_rdata` one cycle later. Each register accepts a single access size. A request of any other size is dropped, reads as zero and raises `rsp_err` for one cycle. The power-fail input is asynchronous and passes through a synchronizer before its edges update the status.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `irq` is high exactly when power-fail status (aux2 bit 5) and power-interrupt enable (config bit 3) are both set. It follows a config write, an aux2 write or a power-fail edge at the same clock edge that updates those registers.
- R2: Each edge of the synchronized power-fail input reloads the status bit. It becomes 1 when the input is high and config bit 3 is set, and 0 otherwise. Status changes three clock edges after the input changes, and it does not change without an edge.
- R3: A write to aux1 (select 3) with bit 1 set gives a `tc_pulse` exactly one clock wide. Bit 1 is never stored and reads back as 0. All other bits are stored as written.
- R4: An aux2 write (select 4) keeps write bits 0 and 1 and merges in the current status bit 5. If write bit 1 is set, the stored value becomes only bit 0, which clears the status. Bit 1 always reads back 0.
- R5: `pwroff_req` is high exactly while stored aux2 bit 0 is set.
- R6: A 32-bit write to system control (select 6) at offset 0 with bit 0 set loads the value 0x02 and gives a one-clock `rst_req`. Writes at other offsets, and writes with bit 0 clear, have no effect. Reads at other offsets return 0.
- R7: A `soft_rst` cycle clears config, aux1, aux2 and modem control, and drops `irq` and `pwroff_req`. The diagnostic, LED and system-control contents are kept.
- R8: Size code 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. Selects 0 to 4 take 8-bit accesses only, select 5 takes 16-bit only and select 6 takes 32-bit only. Any other size, and select 7, is ignored on write, reads 0 and pulses `rsp_err` for one cycle.
- R9: Config (select 0), diagnostic (1), modem (2) and LED (5) store the written value and return it on a read. Read data is registered and valid the cycle after the request.
- R10: `rst` clears every register and output, including the diagnostic, LED and system-control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Synchronous partial reset of the control registers |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select |
| req_ofs | input | OFS_W | Byte offset within the selected register |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle flag for an access of the wrong size |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count strobe |
| pwroff_req | output | 1 | Power-off request level |
| rst_req | output | 1 | System reset-request strobe |
| pwr_fail_in | input | 1 | Asynchronous power-fail level |

## Verification
Plain registers are written with distinct patterns and read back. A pattern of all ones into the auxiliary registers shows the masking and self-clear rules, because every bit that should drop is set. The power-fail input is raised with the enable both off and on, and the enable is then toggled without an input edge. This separates status that is latched on an edge from status that follows the level, and separates status from interrupt gating. Wrong-size reads and writes, non-zero system-control offsets and a soft reset on top of non-zero state show which state each of these touches.

// File: rtl/aux_pkg.sv
package aux_pkg;
  localparam int DATA_W  = 32;
  localparam int REG_W   = 8;
  localparam int LED_W   = 16;
  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  // bit positions software depends on
  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_RST_BIT  = 0;
  localparam logic [REG_W-1:0] SYS_RST_MARK = 8'h02;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG   = 3'd0,
    SEL_DIAG  = 3'd1,
    SEL_MODEM = 3'd2,
    SEL_AUX1  = 3'd3,
    SEL_AUX2  = 3'd4,
    SEL_LED   = 3'd5,
    SEL_SYS   = 3'd6,
    SEL_NONE  = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_RSV = 2'd3
  } size_e;

  function automatic size_e need_size(input sel_e s);
    case (s)
      SEL_LED:  need_size = SZ_16;
      SEL_SYS:  need_size = SZ_32;
      SEL_NONE: need_size = SZ_RSV;
      default:  need_size = SZ_8;
    endcase
  endfunction
endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic chg
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sh;
  logic         prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[MSB-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sh[MSB];
  end

  assign dout = sh[MSB];
  assign chg  = sh[MSB] ^ prev;
endmodule

// File: rtl/aux_decode.sv
module aux_decode
  import aux_pkg::*;
(
  input  logic               req_valid,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic [1:0]         req_size,
  output logic [NUM_SEL-1:0] hit,
  output logic               bad
);
  generate
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      localparam sel_e  SEL_I  = sel_e'(i);
      localparam size_e NEED_I = need_size(SEL_I);
      assign hit[i] = req_valid && (req_sel == SEL_W'(i)) &&
                      (req_size == NEED_I) && (NEED_I != SZ_RSV);
    end
  endgenerate

  assign bad = req_valid && !(|hit);
endmodule

// File: rtl/aux_power.sv
module aux_power
  import aux_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             cfg_pie,
  input  logic             cfg_wr,
  input  logic             aux2_wr,
  input  logic [REG_W-1:0] wbyte,
  input  logic             pf_level,
  input  logic             pf_chg,
  output logic [REG_W-1:0] aux2_q,
  output logic             irq,
  output logic             pwroff
);
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((1 << AUX2_OFF_BIT) | (1 << AUX2_CLR_BIT));
  localparam logic [REG_W-1:0] OFF_MASK  = REG_W'(1 << AUX2_OFF_BIT);

  logic             status_ev;
  logic [REG_W-1:0] aux2_n;
  logic             pie_n;

  always_comb begin
    status_ev = pf_chg ? (pf_level & cfg_pie) : aux2_q[AUX2_PF_BIT];
    if (aux2_wr) begin
      aux2_n = wbyte & KEEP_MASK;
      aux2_n[AUX2_PF_BIT] = status_ev;
      if (wbyte[AUX2_CLR_BIT]) aux2_n = aux2_n & OFF_MASK;
    end else begin
      aux2_n = aux2_q;
      aux2_n[AUX2_PF_BIT] = status_ev;
    end
    pie_n = cfg_wr ? wbyte[CFG_PIE_BIT] : cfg_pie;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      aux2_q <= '0;
      irq    <= 1'b0;
      pwroff <= 1'b0;
    end else begin
      aux2_q <= aux2_n;
      irq    <= aux2_n[AUX2_PF_BIT] & pie_n;
      pwroff <= aux2_n[AUX2_OFF_BIT];
    end
  end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OFS_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              irq,
  output logic              tc_pulse,
  output logic              pwroff_req,
  output logic              rst_req,
  input  logic              pwr_fail_in
);
  localparam logic [REG_W-1:0] TC_CLR = ~REG_W'(1 << AUX1_TC_BIT);

  logic [NUM_SEL-1:0] hit, wr, rd;
  logic               bad;
  logic [REG_W-1:0]   cfg_q, diag_q, modem_q, aux1_q, aux2_q, sys_q;
  logic [LED_W-1:0]   led_q;
  logic [REG_W-1:0]   wbyte;
  logic               pf_level, pf_chg;
  logic [DATA_W-1:0]  rd_mux;
  logic               ofs_zero;

  assign wbyte    = req_wdata[REG_W-1:0];
  assign ofs_zero = (req_ofs == '0);
  assign wr       = hit & {NUM_SEL{req_write}};
  assign rd       = hit & {NUM_SEL{~req_write}};

  aux_decode u_dec (
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .req_size  (req_size),
    .hit       (hit),
    .bad       (bad)
  );

  aux_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pwr_fail_in),
    .dout (pf_level),
    .chg  (pf_chg)
  );

  aux_power u_pwr (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .cfg_pie  (cfg_q[CFG_PIE_BIT]),
    .cfg_wr   (wr[SEL_CFG]),
    .aux2_wr  (wr[SEL_AUX2]),
    .wbyte    (wbyte),
    .pf_level (pf_level),
    .pf_chg   (pf_chg),
    .aux2_q   (aux2_q),
    .irq      (irq),
    .pwroff   (pwroff_req)
  );

  // registers cleared by the partial reset
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg_q   <= '0;
      modem_q <= '0;
      aux1_q  <= '0;
    end else begin
      if (wr[SEL_CFG])   cfg_q   <= wbyte;
      if (wr[SEL_MODEM]) modem_q <= wbyte;
      if (wr[SEL_AUX1])  aux1_q  <= wbyte & TC_CLR;
    end
  end

  // registers kept across the partial reset
  always_ff @(posedge clk) begin
    if (rst) begin
      diag_q <= '0;
      led_q  <= '0;
      sys_q  <= '0;
    end else begin
      if (wr[SEL_DIAG]) diag_q <= wbyte;
      if (wr[SEL_LED])  led_q  <= req_wdata[LED_W-1:0];
      if (wr[SEL_SYS] && ofs_zero && req_wdata[SYS_RST_BIT]) sys_q <= SYS_RST_MARK;
    end
  end

  // strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_pulse <= 1'b0;
      rst_req  <= 1'b0;
      rsp_err  <= 1'b0;
    end else begin
      tc_pulse <= wr[SEL_AUX1] && wbyte[AUX1_TC_BIT];
      rst_req  <= wr[SEL_SYS] && ofs_zero && req_wdata[SYS_RST_BIT];
      rsp_err  <= bad;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd[SEL_CFG])   rd_mux = DATA_W'(cfg_q);
    if (rd[SEL_DIAG])  rd_mux = DATA_W'(diag_q);
    if (rd[SEL_MODEM]) rd_mux = DATA_W'(modem_q);
    if (rd[SEL_AUX1])  rd_mux = DATA_W'(aux1_q);
    if (rd[SEL_AUX2])  rd_mux = DATA_W'(aux2_q);
    if (rd[SEL_LED])   rd_mux = DATA_W'(led_q);
    if (rd[SEL_SYS] && ofs_zero) rd_mux = DATA_W'(sys_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_rdata <= '0;
    else if (req_valid && !req_write) rsp_rdata <= rd_mux;
  end
endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk
  import aux_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [SEL_W-1:0]  req_sel,
  input logic [1:0]        req_size,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_err,
  input logic              irq,
  input logic              tc_pulse,
  input logic              pwroff_req,
  input logic              rst_req,
  input logic [REG_W-1:0]  cfg_q,
  input logic [REG_W-1:0]  aux1_q,
  input logic [REG_W-1:0]  aux2_q,
  input logic [REG_W-1:0]  sys_q
);
  a_r1_irq_gating: assert property (@(posedge clk) disable iff (rst)
    irq == (aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PIE_BIT]));

  a_r3_tc_cause: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> $past(req_valid && req_write && req_sel == SEL_AUX1 &&
                       req_size == SZ_8 && req_wdata[AUX1_TC_BIT]));

  a_r3_tc_not_stored: assert property (@(posedge clk) disable iff (rst)
    !aux1_q[AUX1_TC_BIT]);

  a_r4_aux2_bits: assert property (@(posedge clk) disable iff (rst)
    (aux2_q & 8'hDE) == 8'h00);

  a_r5_pwroff_level: assert property (@(posedge clk) disable iff (rst)
    pwroff_req == aux2_q[AUX2_OFF_BIT]);

  a_r6_rst_mark: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> sys_q == SYS_RST_MARK);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid));
endmodule

bind aux_sysctl_regs aux_sysctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_sel    (req_sel),
  .req_size   (req_size),
  .req_wdata  (req_wdata),
  .rsp_err    (rsp_err),
  .irq        (irq),
  .tc_pulse   (tc_pulse),
  .pwroff_req (pwroff_req),
  .rst_req    (rst_req),
  .cfg_q      (cfg_q),
  .aux1_q     (aux1_q),
  .aux2_q     (aux2_q),
  .sys_q      (sys_q)
);

// File: tb/tb_aux_sysctl_regs.sv
module tb_aux_sysctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;
  // {req(4), wr(1), sel(3), ofs(2), size(2), wdata(32), expected read(32)}
  localparam logic [75:0] VEC [NVEC] = '{
    {4'd9, 1'b1, 3'd0, 2'd0, 2'd0, 32'h0000_00A5, 32'h0},          // R9 cfg
    {4'd9, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0, 32'h0000_00A5},
    {4'd9, 1'b1, 3'd1, 2'd0, 2'd0, 32'h0000_003C, 32'h0},          // R9 diag
    {4'd9, 1'b0, 3'd1, 2'd0, 2'd0, 32'h0, 32'h0000_003C},
    {4'd9, 1'b1, 3'd2, 2'd0, 2'd0, 32'h0000_005A, 32'h0},          // R9 modem
    {4'd9, 1'b0, 3'd2, 2'd0, 2'd0, 32'h0, 32'h0000_005A},
    {4'd9, 1'b1, 3'd5, 2'd0, 2'd1, 32'h0000_BEEF, 32'h0},          // R9 led
    {4'd9, 1'b0, 3'd5, 2'd0, 2'd1, 32'h0, 32'h0000_BEEF},
    {4'd3, 1'b1, 3'd3, 2'd0, 2'd0, 32'h0000_00FF, 32'h0},          // R3 aux1
    {4'd3, 1'b0, 3'd3, 2'd0, 2'd0, 32'h0, 32'h0000_00FD},
    {4'd4, 1'b1, 3'd4, 2'd0, 2'd0, 32'h0000_00FF, 32'h0},          // R4 aux2 mask
    {4'd4, 1'b0, 3'd4, 2'd0, 2'd0, 32'h0, 32'h0000_0001},
    {4'd4, 1'b1, 3'd4, 2'd0, 2'd0, 32'h0000_0000, 32'h0},
    {4'd4, 1'b0, 3'd4, 2'd0, 2'd0, 32'h0, 32'h0000_0000},
    {4'd8, 1'b1, 3'd0, 2'd0, 2'd1, 32'h0000_0000, 32'h0},          // R8 bad size write
    {4'd8, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0, 32'h0000_00A5},
    {4'd8, 1'b0, 3'd0, 2'd0, 2'd2, 32'h0, 32'h0000_0000},          // R8 bad size read
    {4'd8, 1'b1, 3'd5, 2'd0, 2'd0, 32'h0000_1234, 32'h0},
    {4'd8, 1'b0, 3'd5, 2'd0, 2'd1, 32'h0, 32'h0000_BEEF},
    {4'd6, 1'b1, 3'd6, 2'd1, 2'd2, 32'h0000_0001, 32'h0},          // R6 offset 1 write
    {4'd6, 1'b0, 3'd6, 2'd0, 2'd2, 32'h0, 32'h0000_0000},
    {4'd6, 1'b0, 3'd6, 2'd2, 2'd2, 32'h0, 32'h0000_0000},
    {4'd6, 1'b1, 3'd6, 2'd0, 2'd2, 32'hFFFF_FFFE, 32'h0},          // R6 bit 0 clear
    {4'd6, 1'b0, 3'd6, 2'd0, 2'd2, 32'h0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst, soft_rst, req_valid, req_write, pwr_fail_in;
  logic [2:0]  req_sel;
  logic [1:0]  req_ofs, req_size;
  logic [31:0] req_wdata, rsp_rdata;
  logic        rsp_err, irq, tc_pulse, pwroff_req, rst_req;
  int          n_checks = 0;
  int          n_fail = 0;
  logic [31:0] rd_v;
  logic        err_v, tc_v, rr_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_sysctl_regs dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .req_valid(req_valid),
    .req_write(req_write), .req_sel(req_sel), .req_ofs(req_ofs),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .irq(irq), .tc_pulse(tc_pulse),
    .pwroff_req(pwroff_req), .rst_req(rst_req), .pwr_fail_in(pwr_fail_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample after the next rising edge
  task automatic access(input logic w, input logic [2:0] s, input logic [1:0] o,
                        input logic [1:0] z, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_sel = s; req_ofs = o; req_size = z; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd_v = rsp_rdata; err_v = rsp_err; tc_v = tc_pulse; rr_v = rst_req;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; soft_rst = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_sel = '0; req_ofs = '0; req_size = '0; req_wdata = '0; pwr_fail_in = 1'b0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 outputs", {27'd0, irq, tc_pulse, pwroff_req, rst_req, rsp_err}, 32'h0);
    check("R10 rdata", rsp_rdata, 32'h0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][71], VEC[v][70:68], VEC[v][67:66], VEC[v][65:64], VEC[v][63:32]);
      if (!VEC[v][71]) check($sformatf("R%0d vec %0d", VEC[v][75:72], v), rd_v, VEC[v][31:0]);
    end

    // R8 error flag pulse
    access(1'b0, 3'd4, 2'd0, 2'd1, 32'h0);
    check("R8 err pulse", {31'd0, err_v}, 32'h1);
    @(negedge clk);
    check("R8 err one cycle", {31'd0, rsp_err}, 32'h0);
    access(1'b0, 3'd7, 2'd0, 2'd0, 32'h0);
    check("R8 select 7 err", {31'd0, err_v}, 32'h1);

    // R3 terminal-count strobe
    access(1'b1, 3'd3, 2'd0, 2'd0, 32'h0000_0002);
    check("R3 tc high", {31'd0, tc_v}, 32'h1);
    @(negedge clk);
    check("R3 tc one cycle", {31'd0, tc_pulse}, 32'h0);

    // R5 power-off level
    access(1'b1, 3'd4, 2'd0, 2'd0, 32'h0000_0001);
    check("R5 pwroff set", {31'd0, pwroff_req}, 32'h1);
    access(1'b1, 3'd4, 2'd0, 2'd0, 32'h0000_0000);
    check("R5 pwroff clear", {31'd0, pwroff_req}, 32'h0);

    // R2 / R1 power fail with enable on
    access(1'b1, 3'd0, 2'd0, 2'd0, 32'h0000_0008);
    @(negedge clk); pwr_fail_in = 1'b1;
    idle(4);
    check("R1 irq on enabled fail", {31'd0, irq}, 32'h1);
    access(1'b0, 3'd4, 2'd0, 2'd0, 32'h0);
    check("R2 status latched", rd_v, 32'h0000_0020);
    // R4 status survives a plain write, then cleared by bit 1
    access(1'b1, 3'd4, 2'd0, 2'd0, 32'h0000_0001);
    access(1'b0, 3'd4, 2'd0, 2'd0, 32'h0);
    check("R4 status merged", rd_v, 32'h0000_0021);
    access(1'b1, 3'd4, 2'd0, 2'd0, 32'h0000_0002);
    check("R4 clear drops irq", {31'd0, irq}, 32'h0);
    access(1'b0, 3'd4, 2'd0, 2'd0, 32'h0);
    check("R4 cleared value", rd_v, 32'h0000_0000);
    idle(3);
    check("R2 no edge no set", {31'd0, irq}, 32'h0);

    // R2 fail with enable off, then enable without an edge
    @(negedge clk); pwr_fail_in = 1'b0;
    access(1'b1, 3'd0, 2'd0, 2'd0, 32'h0000_0000);
    idle(3);
    @(negedge clk); pwr_fail_in = 1'b1;
    idle(4);
    access(1'b1, 3'd0, 2'd0, 2'd0, 32'h0000_0008);
    check("R2 disabled edge ignored", {31'd0, irq}, 32'h0);
    @(negedge clk); pwr_fail_in = 1'b0;
    idle(4);
    @(negedge clk); pwr_fail_in = 1'b1;
    idle(4);
    check("R1 irq after enabled edge", {31'd0, irq}, 32'h1);
    access(1'b1, 3'd0, 2'd0, 2'd0, 32'h0000_0000);
    check("R1 irq gated by enable", {31'd0, irq}, 32'h0);
    access(1'b0, 3'd4, 2'd0, 2'd0, 32'h0);
    check("R1 status kept", rd_v, 32'h0000_0020);

    // R6 reset request
    access(1'b1, 3'd6, 2'd0, 2'd2, 32'h0000_0001);
    check("R6 rst_req high", {31'd0, rr_v}, 32'h1);
    @(negedge clk);
    check("R6 rst_req one cycle", {31'd0, rst_req}, 32'h0);
    access(1'b0, 3'd6, 2'd0, 2'd2, 32'h0);
    check("R6 reset mark", rd_v, 32'h0000_0002);

    // R7 soft reset
    access(1'b1, 3'd0, 2'd0, 2'd0, 32'h0000_0008);
    access(1'b1, 3'd1, 2'd0, 2'd0, 32'h0000_0077);
    access(1'b1, 3'd2, 2'd0, 2'd0, 32'h0000_0011);
    access(1'b1, 3'd3, 2'd0, 2'd0, 32'h0000_0081);
    access(1'b1, 3'd4, 2'd0, 2'd0, 32'h0000_0001);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R7 irq/pwroff dropped", {30'd0, irq, pwroff_req}, 32'h0);
    access(1'b0, 3'd0, 2'd0, 2'd0, 32'h0); check("R7 cfg cleared", rd_v, 32'h0);
    access(1'b0, 3'd2, 2'd0, 2'd0, 32'h0); check("R7 modem cleared", rd_v, 32'h0);
    access(1'b0, 3'd3, 2'd0, 2'd0, 32'h0); check("R7 aux1 cleared", rd_v, 32'h0);
    access(1'b0, 3'd4, 2'd0, 2'd0, 32'h0); check("R7 aux2 cleared", rd_v, 32'h0);
    access(1'b0, 3'd1, 2'd0, 2'd0, 32'h0); check("R7 diag kept", rd_v, 32'h0000_0077);
    access(1'b0, 3'd5, 2'd0, 2'd1, 32'h0); check("R7 led kept", rd_v, 32'h0000_BEEF);
    access(1'b0, 3'd6, 2'd0, 2'd2, 32'h0); check("R7 sys kept", rd_v, 32'h0000_0002);

    // R10 hard reset clears kept registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    access(1'b0, 3'd1, 2'd0, 2'd0, 32'h0); check("R10 diag cleared", rd_v, 32'h0);
    access(1'b0, 3'd6, 2'd0, 2'd2, 32'h0); check("R10 sys cleared", rd_v, 32'h0);

    finish_run();
  end
endmodule